// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output from a 16-bit period counter. A programmable prescaler divides the input clock, and the counter advances once per divided clock. The output is high while the count is below the active duty sample and low for the rest of the period. Software reaches the block through a small register port with four word addresses. There is a control word, a status word, a sample port and a period register.

Duty samples are not applied at once. A write to the sample address pushes the value into a four-entry queue. The head of that queue becomes the active sample only at a period boundary, so a period is never cut in the middle. The status word shows the queue fill level and a full flag. Software uses these to pace its writes. A write to the period register restarts the count. A software reset bit returns the block to its disabled default state and empties the queue.

Top module: `pwm_fifo_gen`

## Requirements
- R1: Register map on `bus_addr`: 0 is control, 1 is status, 2 is sample (a write queues a value, a read returns the active sample) and 3 is period. Control bits: 0 enable, 1 software reset, 3:2 clock-source select, 4 doze enable, 5 wait enable, 6 debug enable, 19:8 prescaler field. The select and the doze, wait and debug bits are stored and read back unchanged, and have no other effect.
- R2: One full output period lasts (period register + 2) counter steps, with the count running from 0 to period + 1. A period write of 0xFFFF is stored as 0xFFFE, which is also the reset value.
- R3: The counter advances once every (prescaler field + 1) input clocks.
- R4: While enabled, `pwm_out` is high exactly when the count is below the active sample. A sample of 0 gives a constant low, and a sample of at least period + 2 gives a constant high.
- R5: A queued sample becomes active only when the count wraps from period + 1 to 0, or on the events in R6 and R8. If the queue is empty at that point, the active sample is kept.
- R6: A period write while enabled sets the count to 0 at that clock edge, which starts a new period. It also loads the queue head, if there is one, as the active sample.
- R7: The queue holds 4 samples. Status bits 2:0 give the fill level (0 to 4) and bit 3 is the full flag. A sample write while the queue is full is dropped.
- R8: Setting the enable bit while it is clear loads the queue head, if there is one, and starts the count at 0.
- R9: Clearing the enable bit drives `pwm_out` low from the next cycle and holds the count at 0. The queued samples and the active sample are kept.
- R10: Writing 1 to the software-reset bit makes that bit read 1 for exactly one cycle. After that cycle, control reads 0, the queue is empty, the active sample is 0 and the period is 0xFFFE. Any bus write made during that cycle is ignored.
- R11: After reset, control, status and active sample read 0, period reads 0xFFFE and `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, divided by the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with `clk` |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address used for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that the prescaler field is not rewritten while the counter runs. The tick-spacing property allows for a field change, but it does not model one. They also assume that software writes at most one register per cycle and never pops an empty queue; the top module guards the pop with the empty flag. The stimulus does all of its configuration while the block is disabled, or writes only the sample and period registers while it runs. It always waits out the software-reset cycle before its next write, except in the one case that deliberately writes during that cycle. Every waveform window is predicted from a count of 0 at a known clock edge, and each reconfiguration is placed right after such an edge.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_SAMPLE = 2'd2,
    REG_PERIOD = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_SWRST  = 1;
  localparam int CTRL_CLK_LO = 2;
  localparam int CTRL_DOZE   = 4;
  localparam int CTRL_WAIT   = 5;
  localparam int CTRL_DBG    = 6;
  localparam int CTRL_PRE_LO = 8;

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DW-1:0]     push_data,
  input  logic              pop,
  output logic [DW-1:0]     head,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              empty
);

  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [DW-1:0]     slot_q [DEPTH];
  logic              push_ok, pop_ok;

  assign full    = (fill_q == FILL_W'(DEPTH));
  assign empty   = (fill_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign fill    = fill_q;
  assign head    = slot_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    fill_d   = fill_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      fill_d = fill_q + FILL_W'(1);
      else if (pop_ok && !push_ok) fill_d = fill_q - FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      fill_q   <= fill_d;
    end
  end

  // Storage slots: data only, no reset; each slot has its own write enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] data_q;
    logic          we;
    assign we = push_ok && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we) data_q <= push_data;
    end
    assign slot_q[i] = data_q;
  end

  // R7: the fill level never exceeds the depth.
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(DEPTH));

  // R7: a push into a full queue without a pop leaves it full.
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

  // R10: a flush empties the queue on the next cycle.
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R5: the parent never requests a pop on an empty queue.
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_field,
  output logic             tick
);

  logic [PRE_W-1:0] div_cnt_q, div_cnt_d;
  logic             at_limit;

  assign at_limit = (div_cnt_q == div_field);
  assign tick     = run && !restart && at_limit;

  always_comb begin
    if (!run || restart || at_limit) div_cnt_d = '0;
    else                             div_cnt_d = div_cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt_q <= '0;
    else        div_cnt_q <= div_cnt_d;
  end

  // R3: with a divide ratio above one, ticks are never back to back.
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_field != '0) |=> (!tick || div_field == '0));

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] last;

  // The period holds at most 2^CNT_W - 2, so the last count fits in CNT_W bits.
  assign last  = period + CNT_W'(1);
  assign wrap  = run && tick && (count_q == last);
  assign count = count_q;

  always_comb begin
    count_d = count_q;
    if (!run || restart) count_d = '0;
    else if (tick)       count_d = (count_q == last) ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R2: the count stays within 0 .. period + 1.
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= last);

  // R6: a restart puts the count at zero on the next cycle.
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count_q == '0);

  // R9: while not running, the count is held at zero.
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count_q == '0);

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             pwm_out
);

  localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] PERIOD_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  // Reset synchronizer: asynchronous assertion, release aligned to clk.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Control and data registers.
  logic             en_q, en_d;
  logic             swrst_q, swrst_d;
  logic [1:0]       clksel_q, clksel_d;
  logic             doze_q, doze_d, wait_q, wait_d, dbg_q, dbg_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] act_q, act_d;

  logic             wr_ok, ctrl_wr, sample_wr, period_wr;
  logic             en_rise, load, pop;
  logic             tick, wrap;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] head;
  logic [FILL_W-1:0] fill;
  logic             full, empty;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[BUS_W-1:CTRL_PRE_LO+PRE_W], bus_wdata[7]};

  assign wr_ok     = bus_wr && !swrst_q;
  assign ctrl_wr   = wr_ok && (reg_addr_e'(bus_addr) == REG_CTRL);
  assign sample_wr = wr_ok && (reg_addr_e'(bus_addr) == REG_SAMPLE);
  assign period_wr = wr_ok && (reg_addr_e'(bus_addr) == REG_PERIOD);

  assign en_rise = ctrl_wr && !bus_wdata[CTRL_SWRST] && bus_wdata[CTRL_EN] && !en_q;
  assign load    = wrap || en_rise || (period_wr && en_q);
  assign pop     = load && !empty && !swrst_q;

  pwm_sample_fifo #(
    .DW    (CNT_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (swrst_q),
    .push      (sample_wr),
    .push_data (bus_wdata[CNT_W-1:0]),
    .pop       (pop),
    .head      (head),
    .fill      (fill),
    .full      (full),
    .empty     (empty)
  );

  pwm_prescaler #(
    .PRE_W (PRE_W)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (en_q),
    .restart   (period_wr),
    .div_field (pre_q),
    .tick      (tick)
  );

  pwm_period_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (en_q),
    .restart (period_wr),
    .tick    (tick),
    .period  (period_q),
    .count   (count),
    .wrap    (wrap)
  );

  // Next-state logic for the register file.
  always_comb begin
    en_d     = en_q;
    swrst_d  = 1'b0;
    clksel_d = clksel_q;
    doze_d   = doze_q;
    wait_d   = wait_q;
    dbg_d    = dbg_q;
    pre_d    = pre_q;
    period_d = period_q;
    act_d    = act_q;
    if (swrst_q) begin
      en_d     = 1'b0;
      clksel_d = '0;
      doze_d   = 1'b0;
      wait_d   = 1'b0;
      dbg_d    = 1'b0;
      pre_d    = '0;
      period_d = PERIOD_MAX;
      act_d    = '0;
    end else begin
      if (ctrl_wr) begin
        if (bus_wdata[CTRL_SWRST]) begin
          swrst_d = 1'b1;
        end else begin
          en_d     = bus_wdata[CTRL_EN];
          clksel_d = bus_wdata[CTRL_CLK_LO +: 2];
          doze_d   = bus_wdata[CTRL_DOZE];
          wait_d   = bus_wdata[CTRL_WAIT];
          dbg_d    = bus_wdata[CTRL_DBG];
          pre_d    = bus_wdata[CTRL_PRE_LO +: PRE_W];
        end
      end
      if (period_wr) begin
        period_d = (bus_wdata[CNT_W-1:0] > PERIOD_MAX) ? PERIOD_MAX : bus_wdata[CNT_W-1:0];
      end
      if (pop) act_d = head;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q     <= 1'b0;
      swrst_q  <= 1'b0;
      clksel_q <= '0;
      doze_q   <= 1'b0;
      wait_q   <= 1'b0;
      dbg_q    <= 1'b0;
      pre_q    <= '0;
      period_q <= PERIOD_MAX;
      act_q    <= '0;
    end else begin
      en_q     <= en_d;
      swrst_q  <= swrst_d;
      clksel_q <= clksel_d;
      doze_q   <= doze_d;
      wait_q   <= wait_d;
      dbg_q    <= dbg_d;
      pre_q    <= pre_d;
      period_q <= period_d;
      act_q    <= act_d;
    end
  end

  // Read mux.
  always_comb begin
    bus_rdata = '0;
    unique case (reg_addr_e'(bus_addr))
      REG_CTRL: begin
        bus_rdata[CTRL_EN]               = en_q;
        bus_rdata[CTRL_SWRST]            = swrst_q;
        bus_rdata[CTRL_CLK_LO +: 2]      = clksel_q;
        bus_rdata[CTRL_DOZE]             = doze_q;
        bus_rdata[CTRL_WAIT]             = wait_q;
        bus_rdata[CTRL_DBG]              = dbg_q;
        bus_rdata[CTRL_PRE_LO +: PRE_W]  = pre_q;
      end
      REG_STAT: begin
        bus_rdata[FILL_W-1:0] = fill;
        bus_rdata[FILL_W]     = full;
      end
      REG_SAMPLE: bus_rdata[CNT_W-1:0] = act_q;
      REG_PERIOD: bus_rdata[CNT_W-1:0] = period_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign pwm_out = en_q && (count < act_q);

  // R10: the software-reset bit clears itself after one cycle.
  a_r10_swrst_self_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swrst_q |=> !swrst_q);

  // R10: after a software reset the block is disabled.
  a_r10_swrst_disables: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swrst_q |=> !en_q && act_q == '0);

  // R5: the active sample changes only on a load event or a software reset.
  a_r5_active_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && !swrst_q) |=> $stable(act_q));

  // R9: with enable clear, the output stays low.
  a_r9_low_when_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_d && !swrst_q) |=> !pwm_out);

endmodule

// File: tb/pwm_fifo_gen_bench.sv
module pwm_fifo_gen_bench;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pwm_fifo_gen u_pwm_fifo_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // Monitor: pops one expected output bit per cycle and compares it.
  always @(negedge clk) begin
    logic  e;
    string t;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({31'b0, pwm_out}, {31'b0, e}, t);
    end
  end

  // All tasks start and return at posedge + 2ns.
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    @(negedge clk);
    check(bus_rdata, exp, req);
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Driver: predicts the waveform from a count of 0 at the last edge.
  task automatic expect_wave(input int first, input int rest[4], input int n_rest,
                             input int per, input int div, input int n, input string req);
    int act = first;
    int cnt = 0;
    int pre = 0;
    int idx = 0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(cnt < act);
      tag_q.push_back(req);
      pre++;
      if (pre == div) begin
        pre = 0;
        if (cnt == per + 1) begin
          cnt = 0;
          if (idx < n_rest) begin
            act = rest[idx];
            idx++;
          end
        end else begin
          cnt++;
        end
      end
    end
  endtask

  task automatic expect_low(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(1'b0);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);

    // R11: reset state
    rd_chk(2'd0, 32'h0, "R11 ctrl");
    rd_chk(2'd1, 32'h0, "R11 status");
    rd_chk(2'd2, 32'h0, "R11 sample");
    rd_chk(2'd3, 32'h0000_FFFE, "R11 period");
    check({31'b0, pwm_out}, 32'h0, "R11 out");

    // R1: stored control bits read back; R2: period saturation
    wr_reg(2'd0, 32'h000A_BC7C);
    rd_chk(2'd0, 32'h000A_BC7C, "R1 ctrl readback");
    check({31'b0, pwm_out}, 32'h0, "R1 stored bits keep out low");
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h0000_FFFF);
    rd_chk(2'd3, 32'h0000_FFFE, "R2 period saturate");

    // R2 R4 R5 R7 R8: two queued samples, divide 1, period 2 (4 steps)
    wr_reg(2'd3, 32'd2);
    wr_reg(2'd2, 32'd1);
    wr_reg(2'd2, 32'd3);
    rd_chk(2'd1, 32'd2, "R7 fill two");
    wr_reg(2'd0, 32'h1);
    expect_wave(1, '{3, 0, 0, 0}, 1, 2, 1, 16, "R8 R5 R2 queued samples");
    drain();
    rd_chk(2'd1, 32'd0, "R5 queue drained");
    rd_chk(2'd2, 32'd3, "R5 last sample reused");

    // R9: disable
    wr_reg(2'd0, 32'h0);
    expect_low(8, "R9 disabled low");
    drain();
    rd_chk(2'd2, 32'd3, "R9 active kept");
    wr_reg(2'd2, 32'd5);
    idle(3);
    rd_chk(2'd1, 32'd1, "R9 queue kept while disabled");

    // R10: software reset
    wr_reg(2'd0, 32'h2);
    rd_chk(2'd0, 32'h2, "R10 bit visible");
    rd_chk(2'd0, 32'h0, "R10 bit cleared");
    rd_chk(2'd1, 32'h0, "R10 queue flushed");
    rd_chk(2'd2, 32'h0, "R10 active cleared");
    rd_chk(2'd3, 32'h0000_FFFE, "R10 period default");
    wr_reg(2'd0, 32'h2);
    wr_reg(2'd2, 32'd9);
    rd_chk(2'd1, 32'h0, "R10 write ignored");

    // R3 R4: divide 3, period 1 (3 steps), samples 5 (high), 0 (low), 2
    wr_reg(2'd3, 32'd1);
    wr_reg(2'd2, 32'd5);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd2, 32'd2);
    wr_reg(2'd0, 32'h0000_0201);
    expect_wave(5, '{0, 2, 0, 0}, 2, 1, 3, 45, "R3 R4 prescaled constants");
    drain();

    // R6: period write restarts and loads the queued sample
    wr_reg(2'd2, 32'd1);
    wr_reg(2'd3, 32'd3);
    expect_wave(1, '{0, 0, 0, 0}, 0, 3, 3, 30, "R6 period restart");
    drain();
    rd_chk(2'd2, 32'd1, "R6 loaded sample");

    // R7: full queue drops a fifth write
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd0, 32'h2);
    idle(1);
    wr_reg(2'd2, 32'd4);
    wr_reg(2'd2, 32'd3);
    wr_reg(2'd2, 32'd2);
    wr_reg(2'd2, 32'd1);
    wr_reg(2'd2, 32'd9);
    rd_chk(2'd1, 32'h0000_000C, "R7 full flag and level");
    wr_reg(2'd3, 32'd2);
    wr_reg(2'd0, 32'h1);
    expect_wave(4, '{3, 2, 1, 0}, 3, 2, 1, 24, "R7 dropped sample absent");
    drain();
    rd_chk(2'd1, 32'h0, "R7 queue empty");

    finish_run();
  end

endmodule